// File: doc/BRIEF.md
# HDLC Serial Frame Transmitter with Programmable Preamble

This block turns frames held in a byte-wide transmit FIFO into a one-bit HDLC line signal. One line bit is produced for each cycle in which the bit-enable strobe is high. Between frames the line carries back-to-back flags. When the FIFO holds data, the block can first send a programmable 8-bit preamble pattern a configured number of times. It then sends an opening flag and the frame bytes with zero-bit insertion. It ends the frame with a frame check sequence and a closing flag, then returns to idle flags.

The frame check sequence comes from one of two sources. In internal mode the block computes the 16-bit CRC-ITU-T over the frame content and appends it. In pass-through mode the block appends nothing: the last two bytes software placed in the FIFO serve as the checksum, and the block still adds the closing flag itself. The block does not check whether the frame length is sensible.

The controller is a state machine with six states:
- `ST_IDLE` sends idle flags.
- `ST_PRE` sends preamble repetitions.
- `ST_OPEN` sends the opening flag.
- `ST_DATA` sends frame bytes.
- `ST_CRC` sends the two check bytes.
- `ST_CLOSE` sends the closing flag.

Transitions happen only on byte boundaries:
- `ST_IDLE` goes to `ST_PRE` when the FIFO is non-empty and the count is non-zero.
- `ST_IDLE` goes to `ST_OPEN` when the FIFO is non-empty and the count is zero.
- `ST_PRE` goes to `ST_OPEN` after the last repetition.
- `ST_OPEN` goes to `ST_DATA`.
- `ST_DATA` goes to `ST_CRC` after the marked last byte in internal mode.
- `ST_DATA` goes to `ST_CLOSE` after the marked last byte in pass-through mode.
- `ST_CRC` goes to `ST_CLOSE` after the second check byte.
- `ST_CLOSE` goes back to `ST_IDLE`.

Top module: `hdlc_tx_pre`

## Requirements
- R1: After reset `tx_out` is 1 and `fifo_rd` is 0. The first bits on the line form a complete flag.
- R2: While the FIFO is empty the line carries continuous flags. A flag is 0x7E sent LSB first, giving the bit order 0,1,1,1,1,1,1,0.
- R3: `tx_out` changes only on a clock edge where `bit_en` is 1. `fifo_rd` is asserted only together with `bit_en` and a non-empty FIFO.
- R4: A frame starts only on a flag boundary while the FIFO is non-empty. It is preceded by `cfg_pre_count` repetitions of the preamble pattern, and a count of 0 sends no preamble.
- R5: The preamble pattern is sent LSB first with no zero insertion, even when it holds runs of more than five 1s.
- R6: After the opening flag each FIFO byte is sent LSB first, with one `fifo_rd` pulse per byte. The byte presented with `fifo_last` = 1 is the last content byte of the frame.
- R7: Inside content (frame bytes and check bytes) a 0 is inserted after every five consecutive 1s. This also applies across byte boundaries and just before the closing flag. Flag bits are never stuffed.
- R8: In internal mode (`cfg_crc_bypass` = 0) the check is computed with the reflected polynomial 0x8408, preset 0xFFFF, over content bits in line order. It is sent inverted, low byte first, each byte LSB first. For the ASCII content "123456789" the sent check value is 0x906E.
- R9: In pass-through mode (`cfg_crc_bypass` = 1) no check bytes are generated, and the FIFO bytes including the final two are sent unchanged. Any frame length is accepted, including a single byte.
- R10: Every frame ends with a closing flag produced by the block, followed by idle flags.
- R11: The mode, preamble pattern and preamble count are taken at frame start. Changing them during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One line bit is produced per cycle with this high |
| fifo_empty | input | 1 | Transmit FIFO holds no byte |
| fifo_data | input | 8 | Byte at the FIFO head (show-ahead) |
| fifo_last | input | 1 | Head byte is the last of its frame |
| fifo_rd | output | 1 | Pop the FIFO head byte |
| cfg_pre_pattern | input | 8 | Preamble bit pattern, LSB first |
| cfg_pre_count | input | 4 | Number of preamble repetitions (0 = none) |
| cfg_crc_bypass | input | 1 | 1 = check bytes come from the FIFO |
| tx_out | output | 1 | Serial line output |

## Verification
A wrong state or bit count in this block shows up directly in the serial stream. A missing or extra preamble byte, a missing flag or a misplaced byte boundary shifts every later bit, so the mismatch appears within eight bit-enable strobes of the fault. A wrong check value or a missing stuffed zero corrupts the frame tail before the closing flag. A wrong run count in the zero-insertion logic either adds a 0 or lets a sixth 1 through inside the content. A wrong pop decision shows as a FIFO read count that differs from the frame length at the end of the frame.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

    localparam int BYTE_W = 8;
    localparam int FCS_W  = 16;

    localparam logic [BYTE_W-1:0] FLAG_BYTE  = 8'h7E;
    localparam logic [FCS_W-1:0]  FCS_PRESET = 16'hFFFF;
    localparam logic [FCS_W-1:0]  FCS_POLY_R = 16'h8408;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PRE   = 3'd1,
        ST_OPEN  = 3'd2,
        ST_DATA  = 3'd3,
        ST_CRC   = 3'd4,
        ST_CLOSE = 3'd5
    } tx_state_e;

endpackage

// File: rtl/hdlc_tx_fcs.sv
// Bit-serial frame check accumulator, reflected form (LSB of the register
// is the oldest bit). Exposes the low byte of the next value and the high
// byte of the current value, which are the only slices the sequencer sends.
module hdlc_tx_fcs
    import hdlc_tx_pkg::*;
#(
    parameter logic [FCS_W-1:0] POLY   = FCS_POLY_R,
    parameter logic [FCS_W-1:0] PRESET = FCS_PRESET
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              preset_i,
    input  logic              update_i,
    input  logic              din_i,
    output logic [BYTE_W-1:0] lo_next_o,
    output logic [BYTE_W-1:0] hi_now_o
);

    logic [FCS_W-1:0] acc_q;
    logic [FCS_W-1:0] acc_d;
    logic             fb;

    always_comb begin
        fb    = acc_q[0] ^ din_i;
        acc_d = (acc_q >> 1) ^ (fb ? POLY : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= PRESET;
        end else if (preset_i) begin
            acc_q <= PRESET;
        end else if (update_i) begin
            acc_q <= acc_d;
        end
    end

    assign lo_next_o = acc_d[BYTE_W-1:0];
    assign hi_now_o  = acc_q[FCS_W-1:BYTE_W];

endmodule

// File: rtl/hdlc_tx_stuff.sv
// Counts consecutive content 1s already placed on the line and requests one
// inserted 0 once the run reaches RUN_LEN.
module hdlc_tx_stuff #(
    parameter int RUN_LEN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic content_i,
    input  logic bit_i,
    output logic stuff_o
);

    localparam int RW = $clog2(RUN_LEN + 1);

    logic [RW-1:0] run_q;

    assign stuff_o = (run_q == RW'(RUN_LEN));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (tick_i) begin
            if (stuff_o) begin
                run_q <= '0;
            end else if (content_i && bit_i) begin
                run_q <= run_q + RW'(1);
            end else begin
                run_q <= '0;
            end
        end
    end

endmodule

// File: rtl/hdlc_tx_seq.sv
// Frame sequencer: state register, byte shifter, preamble repeat counter.
module hdlc_tx_seq
    import hdlc_tx_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              fifo_empty,
    input  logic [BYTE_W-1:0] fifo_data,
    input  logic              fifo_last,
    input  logic [BYTE_W-1:0] cfg_pre_pattern,
    input  logic [CNT_W-1:0]  cfg_pre_count,
    input  logic              cfg_crc_bypass,
    input  logic              stuff_req_i,
    input  logic [BYTE_W-1:0] fcs_lo_next_i,
    input  logic [BYTE_W-1:0] fcs_hi_i,
    output logic              fifo_rd,
    output logic              tx_out,
    output logic              fcs_preset_o,
    output logic              fcs_update_o,
    output logic              line_bit_o,
    output logic              content_o,
    output tx_state_e         state_o,
    output logic              bypass_o
);

    localparam int BCW = $clog2(BYTE_W);
    localparam logic [BCW-1:0] LAST_BIT = BCW'(BYTE_W - 1);

    tx_state_e         state_q, state_d;
    logic [BYTE_W-1:0] sh_q,    sh_d;
    logic [BCW-1:0]    bcnt_q,  bcnt_d;
    logic [CNT_W-1:0]  rep_q,   rep_d;
    logic [BYTE_W-1:0] pat_q,   pat_d;
    logic              last_q,  last_d;
    logic              half_q,  half_d;
    logic              byp_q,   byp_d;
    logic              tx_q,    tx_d;
    logic              shift_tick;
    logic              byte_end;

    assign shift_tick = bit_en && !stuff_req_i;
    assign byte_end   = shift_tick && (bcnt_q == LAST_BIT);

    // State and datapath register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sh_q    <= FLAG_BYTE;
            bcnt_q  <= '0;
            rep_q   <= '0;
            pat_q   <= '0;
            last_q  <= 1'b0;
            half_q  <= 1'b0;
            byp_q   <= 1'b0;
            tx_q    <= 1'b1;
        end else begin
            state_q <= state_d;
            sh_q    <= sh_d;
            bcnt_q  <= bcnt_d;
            rep_q   <= rep_d;
            pat_q   <= pat_d;
            last_q  <= last_d;
            half_q  <= half_d;
            byp_q   <= byp_d;
            tx_q    <= tx_d;
        end
    end

    // Next-state and next-byte selection
    always_comb begin
        state_d = state_q;
        sh_d    = sh_q;
        bcnt_d  = bcnt_q;
        rep_d   = rep_q;
        pat_d   = pat_q;
        last_d  = last_q;
        half_d  = half_q;
        byp_d   = byp_q;
        tx_d    = tx_q;

        if (bit_en) begin
            if (stuff_req_i) begin
                tx_d = 1'b0;
            end else begin
                tx_d   = sh_q[0];
                sh_d   = sh_q >> 1;
                bcnt_d = bcnt_q + BCW'(1);
            end
        end

        if (byte_end) begin
            unique case (state_q)
                ST_IDLE: begin
                    sh_d = FLAG_BYTE;
                    if (!fifo_empty) begin
                        byp_d = cfg_crc_bypass;
                        if (cfg_pre_count != '0) begin
                            state_d = ST_PRE;
                            pat_d   = cfg_pre_pattern;
                            sh_d    = cfg_pre_pattern;
                            rep_d   = cfg_pre_count - CNT_W'(1);
                        end else begin
                            state_d = ST_OPEN;
                        end
                    end
                end
                ST_PRE: begin
                    if (rep_q == '0) begin
                        state_d = ST_OPEN;
                        sh_d    = FLAG_BYTE;
                    end else begin
                        rep_d = rep_q - CNT_W'(1);
                        sh_d  = pat_q;
                    end
                end
                ST_OPEN: begin
                    state_d = ST_DATA;
                    sh_d    = fifo_data;
                    last_d  = fifo_last;
                end
                ST_DATA: begin
                    if (!last_q) begin
                        sh_d   = fifo_data;
                        last_d = fifo_last;
                    end else if (byp_q) begin
                        state_d = ST_CLOSE;
                        sh_d    = FLAG_BYTE;
                    end else begin
                        state_d = ST_CRC;
                        sh_d    = ~fcs_lo_next_i;
                        half_d  = 1'b0;
                    end
                end
                ST_CRC: begin
                    if (!half_q) begin
                        half_d = 1'b1;
                        sh_d   = ~fcs_hi_i;
                    end else begin
                        state_d = ST_CLOSE;
                        sh_d    = FLAG_BYTE;
                    end
                end
                ST_CLOSE: begin
                    state_d = ST_IDLE;
                    sh_d    = FLAG_BYTE;
                end
                default: begin
                    state_d = ST_IDLE;
                    sh_d    = FLAG_BYTE;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        fifo_rd      = byte_end &&
                       ((state_q == ST_OPEN) || ((state_q == ST_DATA) && !last_q));
        fcs_preset_o = (state_q != ST_DATA) && (state_q != ST_CRC);
        fcs_update_o = shift_tick && (state_q == ST_DATA);
        content_o    = (state_q == ST_DATA) || (state_q == ST_CRC);
        line_bit_o   = sh_q[0];
        tx_out       = tx_q;
        state_o      = state_q;
        bypass_o     = byp_q;
    end

endmodule

// File: rtl/hdlc_tx_pre.sv
module hdlc_tx_pre
    import hdlc_tx_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter int RUN_LEN = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              fifo_empty,
    input  logic [BYTE_W-1:0] fifo_data,
    input  logic              fifo_last,
    output logic              fifo_rd,
    input  logic [BYTE_W-1:0] cfg_pre_pattern,
    input  logic [CNT_W-1:0]  cfg_pre_count,
    input  logic              cfg_crc_bypass,
    output logic              tx_out
);

    logic              stuff_w;
    logic              fcs_preset_w;
    logic              fcs_update_w;
    logic              line_bit_w;
    logic              content_w;
    logic [BYTE_W-1:0] fcs_lo_w;
    logic [BYTE_W-1:0] fcs_hi_w;
    tx_state_e         state_w;
    logic              bypass_w;

    hdlc_tx_seq #(
        .CNT_W (CNT_W)
    ) u_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .bit_en          (bit_en),
        .fifo_empty      (fifo_empty),
        .fifo_data       (fifo_data),
        .fifo_last       (fifo_last),
        .cfg_pre_pattern (cfg_pre_pattern),
        .cfg_pre_count   (cfg_pre_count),
        .cfg_crc_bypass  (cfg_crc_bypass),
        .stuff_req_i     (stuff_w),
        .fcs_lo_next_i   (fcs_lo_w),
        .fcs_hi_i        (fcs_hi_w),
        .fifo_rd         (fifo_rd),
        .tx_out          (tx_out),
        .fcs_preset_o    (fcs_preset_w),
        .fcs_update_o    (fcs_update_w),
        .line_bit_o      (line_bit_w),
        .content_o       (content_w),
        .state_o         (state_w),
        .bypass_o        (bypass_w)
    );

    hdlc_tx_fcs u_fcs (
        .clk       (clk),
        .rst_n     (rst_n),
        .preset_i  (fcs_preset_w),
        .update_i  (fcs_update_w),
        .din_i     (line_bit_w),
        .lo_next_o (fcs_lo_w),
        .hi_now_o  (fcs_hi_w)
    );

    hdlc_tx_stuff #(
        .RUN_LEN (RUN_LEN)
    ) u_stuff (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (bit_en),
        .content_i (content_w),
        .bit_i     (line_bit_w),
        .stuff_o   (stuff_w)
    );

endmodule

// File: rtl/hdlc_tx_pre_chk.sv
module hdlc_tx_pre_chk
    import hdlc_tx_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      bit_en,
    input logic      fifo_empty,
    input logic      fifo_rd,
    input logic      tx_out,
    input tx_state_e state,
    input logic      bypass,
    input logic      stuff_req
);

    logic       prev_tick_q;
    logic       prev_content_q;
    logic [2:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_tick_q    <= 1'b0;
            prev_content_q <= 1'b0;
            run_q          <= '0;
        end else begin
            prev_tick_q    <= bit_en;
            prev_content_q <= stuff_req || (state == ST_DATA) || (state == ST_CRC);
            if (prev_tick_q) begin
                if (prev_content_q && tx_out) begin
                    run_q <= (run_q == 3'd7) ? run_q : run_q + 3'd1;
                end else begin
                    run_q <= '0;
                end
            end
        end
    end

    p_pop_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> !fifo_empty);

    p_pop_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> bit_en);

    p_line_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(tx_out));

    p_stuff_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= 3'd5);

    p_bypass_skips_crc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && bypass) |=> state != ST_CRC);

    p_close_to_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLOSE) |=> (state == ST_CLOSE || state == ST_IDLE));

endmodule

bind hdlc_tx_pre hdlc_tx_pre_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .fifo_empty (fifo_empty),
    .fifo_rd    (fifo_rd),
    .tx_out     (tx_out),
    .state      (state_w),
    .bypass     (bypass_w),
    .stuff_req  (stuff_w)
);

// File: tb/hdlc_tx_pre_tb.sv
module hdlc_tx_pre_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       fifo_empty;
    logic [7:0] fifo_data;
    logic       fifo_last;
    logic       fifo_rd;
    logic [7:0] cfg_pre_pattern = 8'h00;
    logic [3:0] cfg_pre_count = 4'd0;
    logic       cfg_crc_bypass = 1'b0;
    logic       tx_out;

    always #2 clk = ~clk;

    logic [7:0] fifo_mem [0:15];
    int         wr_cnt = 0;
    int         rd_ptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_ptr <= 0;
        else if (fifo_rd) rd_ptr <= rd_ptr + 1;
    end

    assign fifo_empty = (rd_ptr >= wr_cnt);
    assign fifo_data  = fifo_mem[rd_ptr[3:0]];
    assign fifo_last  = !fifo_empty && (rd_ptr == wr_cnt - 1);

    hdlc_tx_pre u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .bit_en          (bit_en),
        .fifo_empty      (fifo_empty),
        .fifo_data       (fifo_data),
        .fifo_last       (fifo_last),
        .fifo_rd         (fifo_rd),
        .cfg_pre_pattern (cfg_pre_pattern),
        .cfg_pre_count   (cfg_pre_count),
        .cfg_crc_bypass  (cfg_crc_bypass),
        .tx_out          (tx_out)
    );

    int n_checks = 0;
    int n_fail   = 0;

    logic exp_bits [0:1023];
    int   exp_n;
    int   m_ones;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] fcs_step(input logic [15:0] c, input logic b);
        logic [15:0] r;
        r = c >> 1;
        if (c[0] ^ b) r = r ^ 16'h8408;
        return r;
    endfunction

    function automatic logic [15:0] fcs_of(input int nb);
        logic [15:0] c;
        c = 16'hFFFF;
        for (int k = 0; k < nb; k++)
            for (int i = 0; i < 8; i++) c = fcs_step(c, fifo_mem[k][i]);
        return ~c;
    endfunction

    task automatic put_bit(input logic b);
        exp_bits[exp_n] = b;
        exp_n++;
    endtask

    task automatic put_raw(input logic [7:0] v);
        for (int i = 0; i < 8; i++) put_bit(v[i]);
        m_ones = 0;
    endtask

    task automatic put_stuffed(input logic [7:0] v);
        for (int i = 0; i < 8; i++) begin
            put_bit(v[i]);
            if (v[i]) m_ones++;
            else m_ones = 0;
            if (m_ones == 5) begin
                put_bit(1'b0);
                m_ones = 0;
            end
        end
    endtask

    task automatic do_reset(input logic [7:0] pat, input logic [3:0] cnt,
                            input logic byp, input int nb);
        bit_en = 1'b0;
        rst_n  = 1'b0;
        cfg_pre_pattern = pat;
        cfg_pre_count   = cnt;
        cfg_crc_bypass  = byp;
        wr_cnt = nb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic tick(output logic b);
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        b = tx_out;
    endtask

    // Generic frame scenario: reset, preload FIFO, stream, compare bit by bit.
    task automatic run_frame(input string req, input logic [7:0] pat,
                             input logic [3:0] cnt, input logic byp,
                             input int nb, input int chg_at);
        logic [15:0] fcs;
        int          bad;
        int          first_bad;
        logic        act_bit;
        logic        got;
        do_reset(pat, cnt, byp, nb);
        exp_n  = 0;
        m_ones = 0;
        put_raw(8'h7E);
        if (nb > 0) begin
            for (int r = 0; r < cnt; r++) put_raw(pat);
            put_raw(8'h7E);
            m_ones = 0;
            for (int k = 0; k < nb; k++) put_stuffed(fifo_mem[k]);
            if (!byp) begin
                fcs = fcs_of(nb);
                put_stuffed(fcs[7:0]);
                put_stuffed(fcs[15:8]);
            end
            put_raw(8'h7E);
        end
        put_raw(8'h7E);
        put_raw(8'h7E);
        bad = 0;
        first_bad = -1;
        act_bit = 1'b0;
        for (int i = 0; i < exp_n; i++) begin
            if (i == chg_at) begin
                cfg_crc_bypass  = ~byp;
                cfg_pre_count   = 4'd0;
                cfg_pre_pattern = 8'hFF;
            end
            tick(got);
            if (got !== exp_bits[i]) begin
                if (first_bad < 0) begin
                    first_bad = i;
                    act_bit = got;
                end
                bad++;
            end
        end
        check(bad == 0, req, $sformatf("line bit %0d", first_bad),
              act_bit, (first_bad < 0) ? 0 : exp_bits[first_bad]);
        check(rd_ptr == nb, req, "bytes popped", rd_ptr, nb);
        check(fifo_empty == 1'b1, req, "fifo drained", fifo_empty, 1);
    endtask

    task automatic t_reset;
        do_reset(8'h00, 4'd0, 1'b0, 0);
        check(tx_out == 1'b1, "R1", "tx_out after reset", tx_out, 1);
        check(fifo_rd == 1'b0, "R1", "fifo_rd after reset", fifo_rd, 0);
    endtask

    task automatic t_idle;
        run_frame("R2", 8'h00, 4'd0, 1'b0, 0, -1);
    endtask

    task automatic t_hold;
        logic b;
        int   moved;
        do_reset(8'h00, 4'd0, 1'b0, 0);
        moved = 0;
        for (int i = 0; i < 16; i++) begin
            tick(b);
            repeat (3) begin
                @(negedge clk);
                if (tx_out !== b) moved++;
            end
        end
        check(moved == 0, "R3", "tx_out moved without bit_en", moved, 0);
        check(rd_ptr == 0, "R3", "pop with empty fifo", rd_ptr, 0);
    endtask

    task automatic t_basic_stuff;
        fifo_mem[0] = 8'hFF; fifo_mem[1] = 8'h3E;
        fifo_mem[2] = 8'h7E; fifo_mem[3] = 8'h00;
        run_frame("R6 R7", 8'h00, 4'd0, 1'b0, 4, -1);
    endtask

    task automatic t_vector;
        for (int k = 0; k < 9; k++) fifo_mem[k] = 8'h31 + 8'(k);
        check(fcs_of(9) == 16'h906E, "R8", "reference check value", fcs_of(9), 16'h906E);
        run_frame("R8", 8'h00, 4'd0, 1'b0, 9, -1);
    endtask

    task automatic t_pre_ones;
        fifo_mem[0] = 8'h55;
        run_frame("R5", 8'hFF, 4'd3, 1'b0, 1, -1);
    endtask

    task automatic t_pre_lsb;
        fifo_mem[0] = 8'hC3; fifo_mem[1] = 8'h12;
        run_frame("R5", 8'h01, 4'd1, 1'b0, 2, -1);
    endtask

    task automatic t_pre_max;
        fifo_mem[0] = 8'hA0;
        run_frame("R4", 8'hA5, 4'd15, 1'b0, 1, -1);
    endtask

    task automatic t_bypass;
        fifo_mem[0] = 8'h10; fifo_mem[1] = 8'h20;
        fifo_mem[2] = 8'hAB; fifo_mem[3] = 8'hCD;
        run_frame("R9", 8'h00, 4'd0, 1'b1, 4, -1);
    endtask

    task automatic t_bypass_one;
        fifo_mem[0] = 8'hF8;
        run_frame("R9 R10", 8'h00, 4'd0, 1'b1, 1, -1);
    endtask

    task automatic t_midchange;
        fifo_mem[0] = 8'h81; fifo_mem[1] = 8'h42; fifo_mem[2] = 8'h24;
        run_frame("R11", 8'h0F, 4'd2, 1'b0, 3, 20);
    endtask

    initial begin
        t_reset;
        t_idle;
        t_hold;
        t_basic_stuff;
        t_vector;
        t_pre_ones;
        t_pre_lsb;
        t_pre_max;
        t_bypass;
        t_bypass_one;
        t_midchange;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule